// File: doc/BRIEF.md
# Paged Memory Window Mapper with Programmable Access Timing

The mapper sits between a 24-bit system memory bus and a card that has a 26-bit address space. Software programs five windows through a byte-wide indexed register port. Each window has an inclusive start page, an inclusive stop page, a page offset, a wait-state code and an enable bit, and a page is 4 KB. A one-cycle access strobe presents a system address. The block compares the address's page bits against every enabled window; if several match, the lowest-numbered one wins. From the chosen window it forms a card address by adding the offset to the page bits and passing the 12 in-page bits through unchanged.

When a window matches, the block runs a 16-bit card cycle. The cycle's minimum length in bus clocks is set by the window's wait-state code. The card can stretch the cycle by holding its active-low wait input low. The block pulses `ready` for exactly one clock when the access completes. An address that matches no window completes at once, with `hit` low and no card cycle.

Top module: `memwin_mapper`

## Requirements
- R1: After synchronous reset, every register index reads 0, all windows are disabled, and `hit`, `ready` and `busy` are low.
- R2: Window n (0 to 4) owns indices 10h+8n to 15h+8n. The fields are:
  - +0: start page bits 7:0.
  - +1: bit 7 enable, bits 3:0 start page bits 11:8.
  - +2: stop page bits 7:0.
  - +3: bits 7:6 wait-state code, bits 3:0 stop page bits 11:8.
  - +4: offset bits 7:0.
  - +5: offset bits 13:8 in bits 5:0.

  All other bits, indices +6 and +7, and indices outside 10h to 37h read 0, and writes to them change nothing.
- R3: An enabled window matches when start <= sys_addr[23:12] <= stop, with both bounds inclusive. A disabled window never matches.
- R4: When several enabled windows match, `win_sel` reports the lowest-numbered one, and its offset and timing are used.
- R5: `card_addr` is {(sys_addr[23:12] + offset) mod 2^14, sys_addr[11:0]}, and it stays constant for the whole access.
- R6: A strobe accepted at clock edge 0 on a hit gives `ready` during cycle 3+code after that edge when the wait input is high. Codes 00, 01, 10 and 11 give 3, 4, 5 and 6 clocks.
- R7: The wait input low before the minimum count is reached has no effect. The wait input low at or after the minimum count holds `ready` low until the first cycle in which it is high.
- R8: `ready` lasts one cycle, after which `busy` is low. A strobe that arrives while `busy` is high is ignored.
- R9: On a miss, `ready` rises in cycle 1 after the strobe edge with `hit` low, whatever the wait input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_idx | input | 6 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_idx (combinational) |
| acc_start | input | 1 | Access strobe, one cycle |
| sys_addr | input | 24 | System memory address, sampled with the strobe |
| card_wait_n | input | 1 | Card wait request, active low |
| hit | output | 1 | Current access matched a window |
| win_sel | output | 3 | Index of the matching window |
| card_addr | output | 26 | Translated card address |
| ready | output | 1 | Access complete, one-cycle pulse |
| busy | output | 1 | Access in progress |

## Verification
A corrupt window field shows up at the very next access that touches the window: as a wrong `win_sel`, a wrong `card_addr`, or `hit` at a page boundary where none should be. A bad field also reads back wrong through the register port in the same cycle it is read. Faults in the cycle counter change the edge in which `ready` appears. The bench therefore counts clocks from the strobe edge and rejects an early or late pulse by even one cycle. A stuck busy state shows up as a missing `ready` or as `busy` still high on the cycle after the pulse.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    localparam int NUM_WIN    = 5;
    localparam int SYS_AW     = 24;
    localparam int PAGE_LSB   = 12;
    localparam int CARD_AW    = 26;
    localparam int IDX_W      = 6;
    localparam int GRP_BASE   = 16;
    localparam int GRP_STRIDE = 8;
    localparam int BASE_CYC   = 3;
    localparam int WS_W       = 2;

    localparam int PAGE_W = SYS_AW - PAGE_LSB;
    localparam int OFS_W  = CARD_AW - PAGE_LSB;
    localparam int WIN_W  = $clog2(NUM_WIN);
    localparam int SUB_W  = $clog2(GRP_STRIDE);
    localparam int CNT_W  = $clog2(BASE_CYC + (1 << WS_W));

    typedef struct packed {
        logic              en;
        logic [WS_W-1:0]   ws;
        logic [PAGE_W-1:0] start;
        logic [PAGE_W-1:0] stop;
        logic [OFS_W-1:0]  ofs;
    } win_cfg_t;

    typedef struct packed {
        logic               hit;
        logic [WIN_W-1:0]   win;
        logic [CARD_AW-1:0] caddr;
        logic [CNT_W-1:0]   len;
    } decode_t;

    typedef enum logic [SUB_W-1:0] {
        F_START_LO = 3'd0,
        F_START_HI = 3'd1,
        F_STOP_LO  = 3'd2,
        F_STOP_HI  = 3'd3,
        F_OFS_LO   = 3'd4,
        F_OFS_HI   = 3'd5
    } field_e;

    function automatic logic [CNT_W-1:0] cycles_for(logic [WS_W-1:0] ws);
        return CNT_W'(BASE_CYC) + CNT_W'(ws);
    endfunction

    function automatic logic [CARD_AW-1:0] translate(logic [SYS_AW-1:0] a,
                                                     logic [OFS_W-1:0] ofs);
        logic [OFS_W-1:0] pg;
        pg = OFS_W'(a[SYS_AW-1:PAGE_LSB]) + ofs;
        return {pg, a[PAGE_LSB-1:0]};
    endfunction
endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
    import memwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [IDX_W-1:0]     idx,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output win_cfg_t [NUM_WIN-1:0] cfg
);
    localparam int SEL_W = IDX_W - SUB_W;

    logic [IDX_W-1:0] rel;
    logic [SEL_W-1:0] sel;
    field_e           fld;
    logic             in_range;

    assign rel      = idx - IDX_W'(GRP_BASE);
    assign sel      = rel[IDX_W-1:SUB_W];
    assign fld      = field_e'(rel[SUB_W-1:0]);
    assign in_range = (idx >= IDX_W'(GRP_BASE)) && (sel < SEL_W'(NUM_WIN));

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[w] <= '0;
            end else if (wr && in_range && sel == SEL_W'(w)) begin
                case (fld)
                    F_START_LO: cfg[w].start[7:0] <= wdata;
                    F_START_HI: begin
                        cfg[w].en                <= wdata[7];
                        cfg[w].start[PAGE_W-1:8] <= wdata[PAGE_W-9:0];
                    end
                    F_STOP_LO:  cfg[w].stop[7:0] <= wdata;
                    F_STOP_HI: begin
                        cfg[w].ws               <= wdata[7:6];
                        cfg[w].stop[PAGE_W-1:8] <= wdata[PAGE_W-9:0];
                    end
                    F_OFS_LO:   cfg[w].ofs[7:0] <= wdata;
                    F_OFS_HI:   cfg[w].ofs[OFS_W-1:8] <= wdata[OFS_W-9:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        win_cfg_t c;
        c     = '0;
        rdata = '0;
        if (in_range) begin
            c = cfg[WIN_W'(sel)];
            case (fld)
                F_START_LO: rdata = c.start[7:0];
                F_START_HI: rdata = {c.en, 3'b000, c.start[PAGE_W-1:8]};
                F_STOP_LO:  rdata = c.stop[7:0];
                F_STOP_HI:  rdata = {c.ws, 2'b00, c.stop[PAGE_W-1:8]};
                F_OFS_LO:   rdata = c.ofs[7:0];
                F_OFS_HI:   rdata = {2'b00, c.ofs[OFS_W-1:8]};
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/memwin_decode.sv
module memwin_decode
    import memwin_pkg::*;
(
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic [SYS_AW-1:0]      addr,
    output decode_t                dec
);
    logic [PAGE_W-1:0] page;
    assign page = addr[SYS_AW-1:PAGE_LSB];

    // Scan from the highest window down so the lowest matching one is kept.
    always_comb begin
        dec     = '0;
        dec.len = CNT_W'(1);
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (cfg[i].en && page >= cfg[i].start && page <= cfg[i].stop) begin
                dec.hit   = 1'b1;
                dec.win   = WIN_W'(i);
                dec.caddr = translate(addr, cfg[i].ofs);
                dec.len   = cycles_for(cfg[i].ws);
            end
        end
    end
endmodule

// File: rtl/memwin_timer.sv
module memwin_timer
    import memwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  decode_t            dec,
    input  logic               card_wait_n,
    output logic               busy,
    output logic               hit,
    output logic [WIN_W-1:0]   win,
    output logic [CARD_AW-1:0] card_addr,
    output logic               ready
);
    decode_t          cur;
    logic [CNT_W-1:0] cnt;

    // The wait input only matters once the minimum count is reached.
    assign ready     = busy && (cnt == cur.len) && (card_wait_n || !cur.hit);
    assign hit       = busy && cur.hit;
    assign win       = cur.win;
    assign card_addr = cur.caddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            cur  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= CNT_W'(1);
                cur  <= dec;
            end
        end else if (ready) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (cnt != cur.len) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Independent count of busy cycles, used by the checks.
    logic [7:0] elapsed;
    always_ff @(posedge clk) begin
        if (rst || !busy) elapsed <= '0;
        else if (elapsed != 8'hFF) elapsed <= elapsed + 8'd1;
    end

    assert_ready_single_R8: assert property (@(posedge clk) disable iff (rst)
        ready |=> (!ready && !busy));
    assert_wait_stretch_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && !card_wait_n) |-> !ready);
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(card_addr));
    assert_min_cycles_R6: assert property (@(posedge clk) disable iff (rst)
        (ready && hit) |-> (elapsed + 8'd1 >= 8'(BASE_CYC)));
    assert_miss_fast_R9: assert property (@(posedge clk) disable iff (rst)
        (ready && !hit) |-> (elapsed == 8'd0));
endmodule

// File: rtl/memwin_mapper.sv
module memwin_mapper
    import memwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               acc_start,
    input  logic [SYS_AW-1:0]  sys_addr,
    input  logic               card_wait_n,
    output logic               hit,
    output logic [WIN_W-1:0]   win_sel,
    output logic [CARD_AW-1:0] card_addr,
    output logic               ready,
    output logic               busy
);
    win_cfg_t [NUM_WIN-1:0] cfg;
    decode_t                dec;

    memwin_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
    );

    memwin_decode u_dec (.cfg(cfg), .addr(sys_addr), .dec(dec));

    memwin_timer u_tmr (
        .clk(clk), .rst(rst), .start(acc_start), .dec(dec),
        .card_wait_n(card_wait_n), .busy(busy), .hit(hit),
        .win(win_sel), .card_addr(card_addr), .ready(ready)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !ready && !hit));
    assert_busy_ignores_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !ready && acc_start) |=> (busy && $stable(win_sel)));
endmodule

// File: tb/test_memwin_mapper.sv
module test_memwin_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        acc_start = 1'b0;
    logic [23:0] sys_addr = '0;
    logic        card_wait_n = 1'b1;
    logic        hit;
    logic [2:0]  win_sel;
    logic [25:0] card_addr;
    logic        ready;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    bit         m_en   [5];
    bit [1:0]   m_ws   [5];
    bit [11:0]  m_start[5];
    bit [11:0]  m_stop [5];
    bit [13:0]  m_ofs  [5];

    memwin_mapper i_memwin_mapper (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_start(acc_start),
        .sys_addr(sys_addr), .card_wait_n(card_wait_n), .hit(hit),
        .win_sel(win_sel), .card_addr(card_addr), .ready(ready), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [5:0] i, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [5:0] i, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_idx = i;
        #1;
        chk(reg_rdata == exp, req, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic set_win(input int w, input bit en, input bit [11:0] s,
                           input bit [11:0] e, input bit [13:0] o, input bit [1:0] ws);
        logic [5:0] b;
        b = 6'(16 + 8 * w);
        wreg(b + 6'd0, s[7:0]);
        wreg(b + 6'd1, {en, 3'b000, s[11:8]});
        wreg(b + 6'd2, e[7:0]);
        wreg(b + 6'd3, {ws, 2'b00, e[11:8]});
        wreg(b + 6'd4, o[7:0]);
        wreg(b + 6'd5, {2'b00, o[13:8]});
        m_en[w] = en; m_start[w] = s; m_stop[w] = e; m_ofs[w] = o; m_ws[w] = ws;
    endtask

    // Expected access result from the model; the lowest matching window wins.
    task automatic expect_acc(input logic [23:0] a, input int hold, output bit eh,
                              output int ew, output logic [25:0] ea, output int elen);
        bit [13:0] pg;
        eh = 0; ew = 0; ea = '0; elen = 1;
        for (int i = 4; i >= 0; i--) begin
            if (m_en[i] && a[23:12] >= m_start[i] && a[23:12] <= m_stop[i]) begin
                eh = 1; ew = i;
                pg = 14'(a[23:12]) + m_ofs[i];
                ea = {pg, a[11:0]};
                elen = 3 + int'(m_ws[i]);
            end
        end
        if (eh && hold + 1 > elen) elen = hold + 1;
    endtask

    task automatic do_acc(input logic [23:0] a, input int hold, input bit poke,
                          input string req);
        bit eh; int ew; logic [25:0] ea; int elen; int k; bit got;
        expect_acc(a, hold, eh, ew, ea, elen);
        @(negedge clk);
        sys_addr = a; acc_start = 1'b1; card_wait_n = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        if (poke) begin acc_start = 1'b1; sys_addr = ~a; end
        k = 1; got = 0;
        while (!got && k < 64) begin
            card_wait_n = (k > hold);
            #1;
            if (ready) begin
                got = 1;
            end else begin
                @(negedge clk);
                acc_start = 1'b0;
                k++;
            end
        end
        chk(got && k == elen, {req, " ready cycle"}, 32'(k), 32'(elen));
        chk(hit == eh, {req, " hit"}, 32'(hit), 32'(eh));
        if (eh) begin
            chk(win_sel == 3'(ew), {req, " window R4"}, 32'(win_sel), 32'(ew));
            chk(card_addr == ea, {req, " card address R5"}, 32'(card_addr), 32'(ea));
        end
        @(negedge clk);
        acc_start = 1'b0; card_wait_n = 1'b1;
        #1;
        chk(!ready && !busy, "R8 single ready then idle", {30'd0, ready, busy}, 32'd0);
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1337));
        for (int i = 0; i < 5; i++) begin
            m_en[i] = 0; m_ws[i] = 0; m_start[i] = 0; m_stop[i] = 0; m_ofs[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!hit && !ready && !busy, "R1 idle outputs", {29'd0, hit, ready, busy}, 32'd0);
        for (int i = 0; i < 64; i++) rreg(6'(i), 8'h00, "R1 register reset");

        // R2: fill every bit of window 2 and check the masks
        for (int f = 0; f < 8; f++) wreg(6'(16 + 16 + f), 8'hFF);
        rreg(6'h20, 8'hFF, "R2 start lo");
        rreg(6'h21, 8'h8F, "R2 start hi");
        rreg(6'h22, 8'hFF, "R2 stop lo");
        rreg(6'h23, 8'hCF, "R2 stop hi");
        rreg(6'h24, 8'hFF, "R2 offset lo");
        rreg(6'h25, 8'h3F, "R2 offset hi");
        rreg(6'h26, 8'h00, "R2 spare index");
        wreg(6'h0F, 8'hA5); wreg(6'h38, 8'h5A); wreg(6'h3F, 8'hFF);
        rreg(6'h0F, 8'h00, "R2 below range");
        rreg(6'h38, 8'h00, "R2 above range");
        rreg(6'h18, 8'h00, "R2 neighbour untouched");
        set_win(2, 0, 12'h000, 12'h000, 14'h0, 2'd0);

        // R3/R9: a disabled window covering everything never matches
        set_win(0, 0, 12'h000, 12'hFFF, 14'h0100, 2'd3);
        do_acc(24'h123456, 0, 0, "R3 R9 disabled miss");
        do_acc(24'h123456, 4, 0, "R9 miss ignores wait");

        // R3/R5: inclusive bounds
        set_win(1, 1, 12'h120, 12'h12F, 14'h0040, 2'd0);
        do_acc(24'h11FFFF, 0, 0, "R3 below start");
        do_acc(24'h120000, 0, 0, "R3 start page");
        do_acc(24'h12F123, 0, 0, "R3 R5 stop page");
        do_acc(24'h130000, 0, 0, "R3 above stop");

        // R4: overlap, lower window wins; upper window alone beyond it
        set_win(3, 1, 12'h125, 12'h140, 14'h2000, 2'd3);
        do_acc(24'h125ABC, 0, 0, "R4 overlap");
        do_acc(24'h135001, 0, 0, "R4 R6 upper only");

        // R5: offset wraps modulo 2^14 pages
        set_win(4, 1, 12'hF00, 12'hFFF, 14'h3FFF, 2'd1);
        do_acc(24'hF80777, 0, 0, "R5 wrap");

        // R6: every wait-state code
        for (int ws = 0; ws < 4; ws++) begin
            set_win(1, 1, 12'h120, 12'h12F, 14'h0040, 2'(ws));
            do_acc(24'h121000, 0, 0, "R6 wait code");
        end

        // R7: wait before the minimum is ignored, after it stretches
        set_win(1, 1, 12'h120, 12'h12F, 14'h0040, 2'd1);
        do_acc(24'h122000, 2, 0, "R7 early wait ignored");
        do_acc(24'h122000, 3, 0, "R7 wait at minimum");
        do_acc(24'h122000, 9, 0, "R7 long wait");

        // R8: strobe while busy is ignored
        do_acc(24'h123000, 0, 1, "R8 strobe while busy");
        do_acc(24'h000000, 0, 1, "R8 strobe during miss");

        // Random configurations and accesses
        for (int n = 0; n < 300; n++) begin
            logic [23:0] a; int w; int span;
            if (n % 25 == 0) begin
                for (int i = 0; i < 5; i++) begin
                    bit [11:0] s; bit [11:0] e; int sp;
                    s = 12'($urandom);
                    sp = int'($urandom % 96);
                    e = (int'(s) + sp > 4095) ? 12'hFFF : 12'(int'(s) + sp);
                    set_win(i, ($urandom % 5) != 0, s, e, 14'($urandom), 2'($urandom));
                end
            end
            w = int'($urandom % 5);
            span = int'(m_stop[w]) - int'(m_start[w]) + 1;
            a = 24'($urandom);
            if (($urandom % 4) != 0)
                a[23:12] = 12'(int'(m_start[w]) + int'($urandom % 32'(span)));
            do_acc(a, int'($urandom % 8), ($urandom % 6) == 0, "R3 R4 R5 R6 R7 random");
        end

        // R2 readback of the random setup
        for (int i = 0; i < 5; i++) begin
            d = {m_en[i], 3'b000, m_start[i][11:8]};
            rreg(6'(16 + 8 * i + 1), d, "R2 readback start hi");
            d = {m_ws[i], 2'b00, m_stop[i][11:8]};
            rreg(6'(16 + 8 * i + 3), d, "R2 readback stop hi");
        end
        finish_run();
    end
endmodule